// File: doc/BRIEF.md
# Input gating with hold latch

This block sits between a bank of input pins and the logic that consumes them, and stops chosen inputs from toggling the internal nets. One blocking rail, taken from a single designated internal logic output, decides when gating is active. A per-pin participation mask chooses which inputs obey the rail. While the rail is high, every participating input shows internal logic a frozen copy of the value it held when the block began. Inputs outside the mask always pass straight through. The rail itself is brought out on an observation pin so that it can be watched from outside.

The implementation is clocked. The pins, the mask and the selected rail source first pass through a synchronizer chain of `SYNC_STAGES` registers, so all three are sampled at the same instant. Each pin then has a one-register capture cell. That cell loads the synchronized pin while the pin is open and keeps its value while the pin is blocked. This clocked cell does the job of a transparent hold latch without any clock-free storage. A synchronous active-high reset clears every register, so after reset the rail is low and all inputs pass through.

Behaviour is defined per sample instant t, meaning the posedge at which `pin_in`, `part_mask` and `rail_cand` are captured. If the selected rail bit and mask bit i were both 1 at t, output bit i keeps the value it had before. Otherwise output bit i takes the pin value from t. The result appears on `core_out` after the edge t + `SYNC_STAGES`, which is `SYNC_STAGES`+1 edges after the inputs were applied.

Top module: `input_gate_hold`

## Requirements
- R1: While `rst` is 1 at a clock edge, every register clears, so `core_out` reads all zeros and `rail_obs` reads 0, whatever the other inputs are.
- R2: While the selected rail is 0, every `core_out` bit equals the matching `pin_in` bit sampled `SYNC_STAGES`+1 edges earlier, for any mask value, and keeps its old value until that edge.
- R3: While the selected rail is 1 and `part_mask` bit i is 1 (1 means the pin participates), `core_out` bit i holds the last value it passed. A pin change sampled together with the rail's rising edge is already blocked.
- R4: A pin whose `part_mask` bit is 0 passes through with the latency of R2 even while the rail is 1.
- R5: When the rail returns to 0, participating pins pass through again starting from the first sample taken with the rail low. A pin value applied together with the rail's falling edge reaches `core_out` `SYNC_STAGES`+1 edges later.
- R6: Only bit `RAIL_IDX` of `rail_cand` drives the rail, and the other candidate bits have no effect on `core_out`. `rail_obs` shows that bit `SYNC_STAGES` edges after it is applied.
- R7: The mask is sampled at the same instant as the pins. Setting a mask bit during a block freezes that output at its current value. Clearing the bit releases the output to pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N | Raw input pins |
| part_mask | input | N | Per-pin participation select, 1 = obeys the rail |
| rail_cand | input | NCAND | Candidate internal logic outputs; bit RAIL_IDX drives the rail |
| core_out | output | N | Gated pin values presented to internal logic |
| rail_obs | output | 1 | Observation copy of the synchronized blocking rail |

## Verification
The assertions check three rules on every cycle: a blocked, participating output never changes; an open or unmasked output follows the synchronized pin one edge later; and reset clears both outputs. Other behaviour can only be shown by the bench scenarios, because it depends on ordering between separate inputs. This covers what value gets frozen when a pin changes in the same sample as the rail's rise, what gets released in the same sample as its fall, and what happens when a mask bit is set during a block. The scenarios also confirm the end-to-end latency, that the unused candidate bits have no effect, and the delay from the rail source to the observation pin.

// File: rtl/ig_pkg.sv
package ig_pkg;
  typedef enum logic {
    IG_PASS = 1'b0,
    IG_HOLD = 1'b1
  } ig_mode_e;

  localparam int IG_DEFAULT_SYNC = 2;
endpackage

// File: rtl/ig_sync_chain.sv
module ig_sync_chain #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/ig_rail_pick.sv
module ig_rail_pick #(
  parameter int NCAND    = 4,
  parameter int RAIL_IDX = 0,
  parameter int DEPTH    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCAND-1:0] cand,
  output logic             rail_s
);
  logic pick;

  assign pick = cand[RAIL_IDX];

  ig_sync_chain #(.W(1), .DEPTH(DEPTH)) u_rail_sync (
    .clk (clk),
    .rst (rst),
    .d   (pick),
    .q   (rail_s)
  );
endmodule

// File: rtl/ig_hold_cell.sv
module ig_hold_cell
  import ig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rail,
  input  logic sel,
  input  logic d,
  output logic q
);
  ig_mode_e mode;

  assign mode = (rail && sel) ? IG_HOLD : IG_PASS;

  always_ff @(posedge clk) begin
    if (rst)                  q <= 1'b0;
    else if (mode == IG_PASS) q <= d;
  end
endmodule

// File: rtl/input_gate_hold.sv
module input_gate_hold
  import ig_pkg::*;
#(
  parameter int N           = 8,
  parameter int NCAND       = 4,
  parameter int RAIL_IDX    = 2,
  parameter int SYNC_STAGES = IG_DEFAULT_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pin_in,
  input  logic [N-1:0]     part_mask,
  input  logic [NCAND-1:0] rail_cand,
  output logic [N-1:0]     core_out,
  output logic             rail_obs
);
  localparam int BUNDLE_W = 2 * N;

  logic [BUNDLE_W-1:0] bundle_raw;
  logic [BUNDLE_W-1:0] bundle_s;
  logic [N-1:0]        pin_s;
  logic [N-1:0]        mask_s;
  logic                rail_s;

  assign bundle_raw = {part_mask, pin_in};

  ig_sync_chain #(.W(BUNDLE_W), .DEPTH(SYNC_STAGES)) u_in_sync (
    .clk (clk),
    .rst (rst),
    .d   (bundle_raw),
    .q   (bundle_s)
  );

  assign pin_s  = bundle_s[N-1:0];
  assign mask_s = bundle_s[BUNDLE_W-1:N];

  ig_rail_pick #(.NCAND(NCAND), .RAIL_IDX(RAIL_IDX), .DEPTH(SYNC_STAGES)) u_rail (
    .clk    (clk),
    .rst    (rst),
    .cand   (rail_cand),
    .rail_s (rail_s)
  );

  assign rail_obs = rail_s;

  for (genvar i = 0; i < N; i++) begin : g_pin
    ig_hold_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .rail (rail_s),
      .sel  (mask_s[i]),
      .d    (pin_s[i]),
      .q    (core_out[i])
    );

    // R3: a blocked participating pin does not move
    a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
      (rail_s && mask_s[i]) |=> $stable(core_out[i]));

    // R2 and R5: an open pin follows its synchronized value
    a_r2_pass_when_open: assert property (@(posedge clk) disable iff (rst)
      !rail_s |=> (core_out[i] == $past(pin_s[i])));

    // R4: an unmasked pin follows even under the rail
    a_r4_unmasked_pass: assert property (@(posedge clk) disable iff (rst)
      !mask_s[i] |=> (core_out[i] == $past(pin_s[i])));
  end

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (core_out == '0 && rail_obs == 1'b0));
endmodule

// File: tb/sim_input_gate_hold.sv
module sim_input_gate_hold;
  localparam int N   = 8;
  localparam int NC  = 4;
  localparam int RI  = 2;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin = '0;
  logic [N-1:0]  msk = '0;
  logic [NC-1:0] cand = '0;
  logic [N-1:0]  core_out;
  logic          rail_obs;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  input_gate_hold #(.N(N), .NCAND(NC), .RAIL_IDX(RI), .SYNC_STAGES(SS)) u0 (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin),
    .part_mask (msk),
    .rail_cand (cand),
    .core_out  (core_out),
    .rail_obs  (rail_obs)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp);
    checks++;
    if (core_out !== exp) begin
      errs++;
      $display("FAIL %s core_out actual=%h expected=%h", req, core_out, exp);
    end
  endtask

  task automatic chk_obs(input string req, input logic exp);
    checks++;
    if (rail_obs !== exp) begin
      errs++;
      $display("FAIL %s rail_obs actual=%b expected=%b", req, rail_obs, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; pin = 8'hFF; msk = 8'hFF; cand = 4'hF;
    edges(4);
    chk("R1 reset clears core_out", 8'h00);
    chk_obs("R1 reset clears rail_obs", 1'b0);
    rst = 1'b0; cand = 4'h0;
    edges(LAT);
    chk("R2 pass after reset", 8'hFF);
  endtask

  task automatic t_pass;
    pin = 8'hA5; msk = 8'hFF;
    edges(LAT - 1);
    chk("R2 value not yet through", 8'hFF);
    edges(1);
    chk("R2 value through at latency", 8'hA5);
    pin = 8'h3C; msk = 8'h00;
    edges(LAT);
    chk("R2 pass independent of mask", 8'h3C);
  endtask

  task automatic t_block_release;
    msk = 8'h0F; pin = 8'h5A;
    edges(LAT);
    chk("R2 settle before block", 8'h5A);
    cand = 4'b0100;
    edges(SS - 1);
    chk_obs("R6 rail_obs not yet high", 1'b0);
    edges(1);
    chk_obs("R6 rail_obs high after sync", 1'b1);
    pin = 8'hFF;
    edges(LAT);
    chk("R3 R4 low nibble held, high nibble passes", 8'hFA);
    pin = 8'h00;
    edges(LAT);
    chk("R3 R4 second pattern", 8'h0A);
    pin = 8'h3C; cand = 4'b0000;
    edges(LAT - 1);
    chk("R5 still held before release reaches output", 8'h0A);
    edges(1);
    chk("R5 same-sample release passes new value", 8'h3C);
    chk_obs("R6 rail_obs low after release", 1'b0);
  endtask

  task automatic t_same_sample_rise;
    msk = 8'hFF; pin = 8'h00;
    edges(LAT);
    chk("R2 settle zeros", 8'h00);
    pin = 8'hFF; cand = 4'b0100;
    edges(LAT);
    chk("R3 change with rail rise is blocked", 8'h00);
    pin = 8'hC3;
    edges(LAT);
    chk("R3 further change ignored", 8'h00);
    cand = 4'b0000;
    edges(LAT);
    chk("R5 release after block", 8'hC3);
  endtask

  task automatic t_other_cand;
    cand = 4'b1011; msk = 8'hFF; pin = 8'h96;
    edges(LAT);
    chk("R6 unselected candidates do not block", 8'h96);
    chk_obs("R6 rail_obs ignores other candidates", 1'b0);
    pin = 8'h69;
    edges(LAT);
    chk("R6 second pattern passes", 8'h69);
    cand = 4'b0000;
  endtask

  task automatic t_mask_mid;
    cand = 4'b0100; msk = 8'h00; pin = 8'h11;
    edges(LAT);
    chk("R4 unmasked under rail", 8'h11);
    msk = 8'h01; pin = 8'h22;
    edges(LAT);
    chk("R7 mask set mid-block freezes bit0", 8'h23);
    msk = 8'h00;
    edges(LAT);
    chk("R7 mask cleared releases bit0", 8'h22);
    cand = 4'b0000;
    edges(LAT);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_block_release();
    t_same_sample_rise();
    t_other_cand();
    t_mask_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule